// File: doc/BRIEF.md
# Serial Real-Time Clock Slave

This block is a time-of-day counter with a small two-wire serial slave in front of it. A prescaler divides the system clock down to one-second ticks. The ticks drive seconds, minutes and hours counters, and each counter carries into the next. The counter values also appear directly on output ports for use inside the chip.

A master reaches the hours counter over the serial lines. The serial clock is an input only. Serial data uses two unidirectional ports: one for data into the slave and one for data out of it. Each transaction opens with a start condition. An address byte follows. After that come one of two things: a command byte with an optional payload byte, or a read of the hour byte. The master can load a new hour or read the current hour. Both serial lines are synchronised into the system clock domain, so the serial clock only needs to be a few times slower than the system clock.

Top module: `rtc_serial_slave`

## Requirements
- R1: During reset, `sec_o`, `min_o` and `hour_o` are 0 and `sda_o` is 1.
- R2: `sec_o` advances once every `TICK_DIV` system clock cycles.
- R3: Seconds count 0 to 59 and then return to 0. That step adds one to the minutes. Minutes also count 0 to 59 and then return to 0.
- R4: When minutes and seconds are both at 59, the next tick moves hours from 23 to 0, or otherwise adds one to hours.
- R5: A falling edge on `sda_i` while `scl_i` is high is a start condition. From any state it discards any partially received bits and begins a new address byte.
- R6: Every byte is received MSB first, with one bit sampled at each rising edge of `scl_i`. In the address byte, bits 7..1 are compared with `DEV_ADDR`. On a mismatch the slave goes idle and ignores everything up to the next start condition.
- R7: Bit 0 of a matching address byte selects the direction. A 1 starts an hour read at once. A 0 means a command byte follows: 0x01 loads the hour, 0x02 reads the hour, and any other value makes the slave go idle.
- R8: After command 0x01, the next byte is loaded into the hours counter if its value is 0 to 23. Larger values are ignored.
- R9: An hour read captures the current hour as an 8-bit value. After each of the next 8 falling edges of `scl_i`, the slave drives one bit onto `sda_o`, MSB first. At the 9th falling edge it releases `sda_o` to 1 and goes idle.
- R10: `sda_o` changes only while the synchronised serial clock is low.
- R11: If an hour load and an hour increment fall in the same cycle, the loaded value wins. Minutes and seconds still wrap to 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Serial data from the master |
| sda_o | output | 1 | Serial data to the master; 1 when idle |
| sec_o | output | 6 | Seconds, 0..59 |
| min_o | output | 6 | Minutes, 0..59 |
| hour_o | output | 5 | Hours, 0..23 |

## Verification
The hardest case to reach from the ports is an hour load that lands in the same cycle as the hour carry at 59:59. The bench holds the serial clock low before the final payload bit and watches `sec_o` and `min_o`. When seconds first reach 59 in minute 59, it raises the serial clock. That timing accounts for the synchroniser and edge-detect latency and for the prescaler phase implied by the seconds change, so the load lands in the carry cycle. The bench then checks that the loaded hour survived and that minutes wrapped. Separate tests cover a repeated start in the middle of an address byte, address and command rejection, and the day wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SEC_W    = 6;
  localparam int unsigned HR_W     = 5;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned SEC_LAST = 59;
  localparam int unsigned HR_LAST  = 23;

  localparam logic [BYTE_W-1:0] CMD_LOAD_HR = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_READ_HR = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK_ADDRESS,
    ST_GET_CMD,
    ST_SET_HR,
    ST_GET_HR
  } rtc_state_e;
endpackage

// File: rtl/rtc_mod_counter.sv
module rtc_mod_counter #(
  parameter int unsigned WIDTH = 6,
  parameter int unsigned LAST  = 59
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] ld_val_i,
  output logic [WIDTH-1:0] val_o
);
  localparam logic [WIDTH-1:0] LastVal = WIDTH'(LAST);

  logic [WIDTH-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (ld_i)     val_q <= ld_val_i;
    else if (inc_i)    val_q <= (val_q == LastVal) ? '0 : val_q + 1'b1;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o
);
  localparam int unsigned NLines = 2;

  logic [NLines-1:0] line_in, line_lvl, line_dly;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLines; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[SYNC_STAGES-2:0], line_in[g]};
    end
    assign line_lvl[g] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_dly <= '1;
    else         line_dly <= line_lvl;
  end

  assign scl_lvl_o  = line_lvl[0];
  assign sda_lvl_o  = line_lvl[1];
  assign scl_rise_o = line_lvl[0] & ~line_dly[0];
  assign scl_fall_o = ~line_lvl[0] & line_dly[0];
  // data falls while clock held high on both samples
  assign start_o    = line_lvl[0] & line_dly[0] & line_dly[1] & ~line_lvl[1];
endmodule

// File: rtl/rtc_serial_fsm.sv
module rtc_serial_fsm
  import rtc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic [HR_W-1:0]   cur_hour_i,
  output logic              sda_o,
  output logic              hr_we_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output rtc_state_e        state_o,
  output logic [IDX_W-1:0]  bit_idx_o
);
  rtc_state_e        state_q, next_st;
  logic [IDX_W-1:0]  bit_idx_q;
  logic [BYTE_W-1:0] shreg_q, tx_q, rx_byte;
  logic              sda_q, byte_done, load_tx;
  logic [2:0]        tx_sel;

  assign rx_byte   = {shreg_q[BYTE_W-2:0], sda_lvl_i};
  assign byte_done = scl_rise_i && (bit_idx_q == '0);
  assign tx_sel    = bit_idx_q[2:0] - 3'd1;

  always_comb begin
    next_st = ST_IDLE;
    case (state_q)
      ST_CHECK_ADDRESS:
        if (rx_byte[7:1] == DEV_ADDR) next_st = rx_byte[0] ? ST_GET_HR : ST_GET_CMD;
      ST_GET_CMD:
        if (rx_byte == CMD_LOAD_HR)      next_st = ST_SET_HR;
        else if (rx_byte == CMD_READ_HR) next_st = ST_GET_HR;
      default: next_st = ST_IDLE;
    endcase
  end

  assign load_tx = (next_st == ST_GET_HR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_idx_q <= IDX_W'(7);
      shreg_q   <= '0;
      tx_q      <= '0;
      sda_q     <= 1'b1;
    end else if (start_i) begin
      state_q   <= ST_CHECK_ADDRESS;
      bit_idx_q <= IDX_W'(7);
      sda_q     <= 1'b1;
    end else begin
      case (state_q)
        ST_CHECK_ADDRESS, ST_GET_CMD, ST_SET_HR: begin
          if (scl_rise_i) begin
            shreg_q <= rx_byte;
            if (bit_idx_q == '0) begin
              state_q <= next_st;
              if (load_tx) begin
                bit_idx_q <= IDX_W'(8);
                tx_q      <= BYTE_W'(cur_hour_i);
              end else begin
                bit_idx_q <= IDX_W'(7);
              end
            end else begin
              bit_idx_q <= bit_idx_q - 1'b1;
            end
          end
        end
        ST_GET_HR: begin
          if (scl_fall_i) begin
            if (bit_idx_q == '0) begin
              sda_q     <= 1'b1;
              state_q   <= ST_IDLE;
              bit_idx_q <= IDX_W'(7);
            end else begin
              sda_q     <= tx_q[tx_sel];
              bit_idx_q <= bit_idx_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_o     = sda_q;
  assign hr_we_o   = (state_q == ST_SET_HR) && byte_done;
  assign rx_byte_o = rx_byte;
  assign state_o   = state_q;
  assign bit_idx_o = bit_idx_q;
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hr_we_i,
  input  logic [BYTE_W-1:0] hr_wdata_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SEC_W-1:0]  min_o,
  output logic [HR_W-1:0]   hour_o
);
  localparam int unsigned PreW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PreW-1:0] PreLast = PreW'(TICK_DIV - 1);
  localparam logic [SEC_W-1:0] SecLast = SEC_W'(SEC_LAST);

  logic [PreW-1:0] pre_q;
  logic tick, sec_carry, min_carry, hr_ld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  assign tick      = (pre_q == PreLast);
  assign sec_carry = tick && (sec_o == SecLast);
  assign min_carry = sec_carry && (min_o == SecLast);
  // load wins over increment inside the counter
  assign hr_ld     = hr_we_i && (hr_wdata_i < BYTE_W'(HR_LAST + 1));

  rtc_mod_counter #(.WIDTH(SEC_W), .LAST(SEC_LAST)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick), .ld_i(1'b0), .ld_val_i('0), .val_o(sec_o)
  );

  rtc_mod_counter #(.WIDTH(SEC_W), .LAST(SEC_LAST)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_carry), .ld_i(1'b0), .ld_val_i('0), .val_o(min_o)
  );

  rtc_mod_counter #(.WIDTH(HR_W), .LAST(HR_LAST)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_carry), .ld_i(hr_ld),
    .ld_val_i(hr_wdata_i[HR_W-1:0]), .val_o(hour_o)
  );
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h68,
  parameter int unsigned TICK_DIV    = 50_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [SEC_W-1:0] min_o,
  output logic [HR_W-1:0]  hour_o
);
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, hr_we;
  logic [BYTE_W-1:0] rx_byte;
  logic [IDX_W-1:0]  bit_idx;
  rtc_state_e        state;

  rtc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_det)
  );

  rtc_serial_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni,
    .sda_lvl_i(sda_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .cur_hour_i(hour_o),
    .sda_o, .hr_we_o(hr_we), .rx_byte_o(rx_byte),
    .state_o(state), .bit_idx_o(bit_idx)
  );

  rtc_timebase #(.TICK_DIV(TICK_DIV)) u_time (
    .clk_i, .rst_ni, .hr_we_i(hr_we), .hr_wdata_i(rx_byte),
    .sec_o, .min_o, .hour_o
  );
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk
  import rtc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_lvl_i,
  input logic              scl_rise_i,
  input logic              start_i,
  input rtc_state_e        state_i,
  input logic [IDX_W-1:0]  bit_idx_i,
  input logic [BYTE_W-1:0] rx_i,
  input logic              hr_we_i,
  input logic              sda_i,
  input logic [SEC_W-1:0]  sec_i,
  input logic [SEC_W-1:0]  min_i,
  input logic [HR_W-1:0]   hour_i
);
  // R3
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sec_i) |-> (sec_i == (($past(sec_i) == 6'd59) ? 6'd0 : $past(sec_i) + 6'd1)));

  // R3
  min_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(min_i) |-> ((min_i == (($past(min_i) == 6'd59) ? 6'd0 : $past(min_i) + 6'd1))
                         && (sec_i == 6'd0)));

  // R4
  hour_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(hour_i) && !$past(hr_we_i)) |->
      (hour_i == (($past(hour_i) == 5'd23) ? 5'd0 : $past(hour_i) + 5'd1)));

  // R5
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == ST_CHECK_ADDRESS) && (bit_idx_i == IDX_W'(7)));

  // R6
  addr_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CHECK_ADDRESS && scl_rise_i && bit_idx_i == '0 && !start_i
     && rx_i[7:1] != DEV_ADDR) |=> (state_i == ST_IDLE));

  // R10
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_i) && !$past(start_i)) |-> !scl_lvl_i);

  // R11
  hour_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_we_i && rx_i < 8'd24) |=> (hour_i == $past(rx_i[HR_W-1:0])));
endmodule

bind rtc_serial_slave rtc_serial_slave_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise),
  .start_i(start_det), .state_i(state), .bit_idx_i(bit_idx), .rx_i(rx_byte),
  .hr_we_i(hr_we), .sda_i(sda_o), .sec_i(sec_o), .min_i(min_o), .hour_i(hour_o)
);

// File: tb/rtc_serial_slave_bench.sv
module rtc_serial_slave_bench;
  localparam logic [6:0]  DEV      = 7'h68;
  localparam int unsigned TICK_DIV = 3;
  localparam int          HALF     = 8;
  localparam logic [7:0]  C_LOAD   = 8'h01;
  localparam logic [7:0]  C_READ   = 8'h02;

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] cmd;
    logic [7:0] arg;
    logic       rd_cmd;
    logic [4:0] exp_hr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{7'h68, 8'h01, 8'd5,  1'b0, 5'd5},   // R8 load, R7 read bit
    '{7'h68, 8'h01, 8'd23, 1'b1, 5'd23},  // R8, R7 read command
    '{7'h68, 8'h01, 8'd24, 1'b0, 5'd23},  // R8 out of range ignored
    '{7'h2C, 8'h01, 8'd9,  1'b1, 5'd23},  // R6 foreign address
    '{7'h68, 8'h01, 8'd0,  1'b0, 5'd0},   // R8 zero
    '{7'h68, 8'h7E, 8'd12, 1'b1, 5'd0},   // R7 unknown command
    '{7'h69, 8'h01, 8'd17, 1'b0, 5'd0},   // R6 address off by one
    '{7'h68, 8'h01, 8'd17, 1'b1, 5'd17}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic sda_o;
  logic [5:0] sec, min;
  logic [4:0] hour;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_serial_slave #(.DEV_ADDR(DEV), .TICK_DIV(TICK_DIV), .SYNC_STAGES(2)) u_rtc_serial_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_o(sda_o), .sec_o(sec), .min_o(min), .hour_o(hour)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_start();
    scl = 1'b1; sda = 1'b1; wait_clk(HALF);
    sda = 1'b0; wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; wait_clk(2);
    sda = b; wait_clk(HALF);
    scl = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_stop();
    scl = 1'b0; wait_clk(2);
    sda = 1'b0; wait_clk(HALF);
    scl = 1'b1; wait_clk(HALF);
    sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic load_frame(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d);
    send_start();
    send_byte({a, 1'b0});
    send_byte(c);
    send_byte(d);
    send_stop();
  endtask

  // hour read; checks bit stability (R10) and release (R9) on the way
  task automatic read_frame(input logic use_cmd, output logic [7:0] v);
    logic stable_ok;
    stable_ok = 1'b1;
    send_start();
    if (use_cmd) begin
      send_byte({DEV, 1'b0});
      send_byte(C_READ);
    end else begin
      send_byte({DEV, 1'b1});
    end
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; wait_clk(2);
      sda = 1'b1; wait_clk(HALF);
      scl = 1'b1; wait_clk(2);
      v[i] = sda_o;
      wait_clk(HALF - 2);
      if (sda_o !== v[i]) stable_ok = 1'b0;
    end
    scl = 1'b0; wait_clk(HALF);
    check("R9 sda_o released after 9th fall", int'(sda_o), 1);
    check("R10 sda_o stable while scl high", int'(stable_ok), 1);
    send_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [5:0] s0, m0;
    logic [4:0] h0;
    int n;

    // R1 reset state
    wait_clk(4);
    check("R1 sec_o in reset", int'(sec), 0);
    check("R1 min_o in reset", int'(min), 0);
    check("R1 hour_o in reset", int'(hour), 0);
    check("R1 sda_o in reset", int'(sda_o), 1);
    rst_n = 1'b1;

    // R2 tick spacing
    s0 = sec;
    do @(negedge clk); while (sec == s0);
    s0 = sec; n = 0;
    do begin @(negedge clk); n++; end while (sec == s0);
    check("R2 cycles per second", n, TICK_DIV);

    // vector table: load frame then read back
    foreach (VECS[k]) begin
      load_frame(VECS[k].addr, VECS[k].cmd, VECS[k].arg);
      check($sformatf("R8 hour_o row %0d", k), int'(hour), int'(VECS[k].exp_hr));
      read_frame(VECS[k].rd_cmd, rd);
      check($sformatf("R9 read value row %0d", k), int'(rd), int'(VECS[k].exp_hr));
    end

    // R5 start in mid address byte restarts the frame
    send_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    load_frame(DEV, C_LOAD, 8'd11);
    check("R5 hour_o after restarted frame", int'(hour), 11);
    read_frame(1'b1, rd);
    check("R5 read after restarted frame", int'(rd), 11);

    // R3 seconds wrap carries into minutes
    do @(negedge clk); while (sec != 6'd59);
    m0 = min;
    do @(negedge clk); while (sec == 6'd59);
    check("R3 seconds wrap to 0", int'(sec), 0);
    check("R3 minute carry", int'(min), (m0 == 6'd59) ? 0 : int'(m0) + 1);

    // R11 hour load aligned with the 59:59 carry
    h0 = hour;
    send_start();
    send_byte({DEV, 1'b0});
    send_byte(C_LOAD);
    for (int i = 7; i >= 1; i--) send_bit(8'd6 >> i);
    scl = 1'b0; wait_clk(2);
    sda = 1'b0;
    do @(negedge clk); while (sec == 6'd59);
    do @(negedge clk); while (!(sec == 6'd59 && min == 6'd59));
    scl = 1'b1;
    wait_clk(HALF);
    send_stop();
    check("R11 loaded hour wins over carry", int'(hour), 6);
    check("R11 minutes wrapped in same tick", int'(min), 0);
    if (h0 == 5'd5) $display("note: prior hour equals 5");

    // R4 day wrap 23 -> 0
    load_frame(DEV, C_LOAD, 8'd23);
    check("R4 hour set to 23", int'(hour), 23);
    do @(negedge clk); while (hour == 5'd23);
    check("R4 hours wrap to 0", int'(hour), 0);
    check("R4 minutes at wrap", int'(min), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule